// File: doc/BRIEF.md
# Temperature-Banded Self-Refresh Pulse Generator

This block produces the periodic refresh request that keeps a DRAM array alive while it sits in self-refresh. A reference clock is first divided into a fixed tick, and the refresh interval is then a whole number of ticks taken from a six-entry period table. The temperature code from an on-die sensor is compared against five programmable band thresholds. Hot bands select short intervals and cold bands select long ones, because cell retention shrinks as the die heats up.

For characterisation and trimming there are two test controls. A remap control lets each temperature band point at any table entry. A manual control ignores temperature altogether and forces one entry. The selection is sampled only at an interval boundary, so an interval already in progress is never cut short. When self-refresh is left part way through an interval that is already mostly spent, the block issues one catch-up pulse before it goes idle, so the refresh that was due is not lost.

Top module: `refresh_rate_gen`

## Requirements
- R1: After reset the block is idle with `refresh_o`, `owed_o` and `period_idx_o` all 0. Every refresh pulse is exactly one clock cycle wide.
- R2: One tick is `TICK_DIV` clock cycles. Period index 0..5 selects 1, 2, 4, 8, 12 and 16 ticks, so consecutive pulses are `ticks*TICK_DIV` cycles apart.
- R3: The band is the number of thresholds i (0..4) for which `temp_code` < threshold i. Threshold i sits in `thr_flat[8i+7:8i]`. Codes are 1.25 °C per LSB, with code 0 = -40 °C and code 160 = 160 °C. With thresholds in descending order, a temperature equal to a threshold belongs to the hotter band, and hotter temperatures give shorter periods.
- R4: With remap and manual both off, the period index equals the band.
- R5: With remap on and manual off, the period index is the field `tm_band_map[3b+2:3b]` for band b. A field value above 5 is treated as 5.
- R6: Manual mode overrides temperature and remap, and the period index becomes `tm_manual_idx`. A value above 5 is treated as 5.
- R7: A changed selection takes effect only at a pulse boundary. `period_idx_o` changes only in the cycle of a pulse or when a run starts, and the interval in progress completes at its old length.
- R8: When `sr_en` is sampled high in idle, a fresh interval starts and `period_idx_o` loads in the next cycle. The first pulse follows `ticks*TICK_DIV` cycles after that sampling edge. While idle, no pulses are issued.
- R9: `owed_o` is high only while running, and only when twice the number of cycles elapsed in the current interval exceeds the interval length in cycles.
- R10: When `sr_en` is sampled low while running, the block goes idle. It emits exactly one catch-up pulse in the following cycle if `owed_o` was high at that edge. If exactly half or less of the interval had elapsed, it emits no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_en | input | 1 | Self-refresh enable |
| temp_code | input | 8 | Temperature code, 1.25 °C per LSB from -40 °C |
| thr_flat | input | 40 | Five band thresholds, 8 bits each, hottest first |
| tm_remap_en | input | 1 | Use the band-to-period map |
| tm_band_map | input | 18 | Period index for each band, 3 bits each |
| tm_manual_en | input | 1 | Force a period index |
| tm_manual_idx | input | 3 | Forced period index |
| refresh_o | output | 1 | One-cycle refresh request |
| period_idx_o | output | 3 | Period index of the running interval |
| owed_o | output | 1 | More than half of the current interval has elapsed |

## Verification
The bound checker watches, on every cycle, that each pulse is one cycle wide, that the index stays in range and moves only at a pulse or a start, that the owed flag never shows while idle, and that the exit pulse follows the owed flag exactly. Only the bench scenarios can show the actual interval lengths for each band and each mode. They also show where the threshold comparison falls at an equal code, that remap and manual mode pick the intended table entries, and that an interval running when the temperature jumps keeps its old length. The exact half-interval point at exit is likewise shown only by the bench.

// File: rtl/rfgen_pkg.sv
package rfgen_pkg;

    localparam int NUM_PER = 6;
    localparam int NUM_THR = NUM_PER - 1;
    localparam int IDX_W   = 3;
    localparam int TICK_W  = 5;

    localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_PER - 1);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    typedef struct packed {
        logic             manual;
        logic             remap;
        logic [IDX_W-1:0] force_idx;
    } sel_ctrl_t;

    // Saturate an index to the last table entry.
    function automatic logic [IDX_W-1:0] clamp_idx(input logic [IDX_W-1:0] v);
        return (v > MAX_IDX) ? MAX_IDX : v;
    endfunction

    // Table: 1,2,4 ticks by doubling, then 8,12,16 in steps of four.
    function automatic logic [TICK_W-1:0] period_ticks(input logic [IDX_W-1:0] idx);
        if (idx < IDX_W'(3))
            return TICK_W'(1) << idx;
        return TICK_W'({idx - IDX_W'(1), 2'b00});
    endfunction

endpackage

// File: rtl/rfgen_band_cmp.sv
module rfgen_band_cmp
    import rfgen_pkg::*;
#(
    parameter int TEMP_W = 8
) (
    input  logic [TEMP_W-1:0]         temp,
    input  logic [NUM_THR*TEMP_W-1:0] thr_flat,
    output logic [IDX_W-1:0]          band
);

    logic [NUM_THR-1:0] below;

    // One comparator per threshold; the band is how many lie above the code.
    for (genvar i = 0; i < NUM_THR; i++) begin : g_cmp
        assign below[i] = temp < thr_flat[i*TEMP_W +: TEMP_W];
    end

    always_comb begin
        band = '0;
        for (int i = 0; i < NUM_THR; i++)
            band = band + IDX_W'(below[i]);
    end

endmodule

// File: rtl/rfgen_period_sel.sv
module rfgen_period_sel
    import rfgen_pkg::*;
(
    input  logic [IDX_W-1:0]         band,
    input  logic [NUM_PER*IDX_W-1:0] map_flat,
    input  sel_ctrl_t                ctrl,
    output logic [IDX_W-1:0]         idx
);

    logic [IDX_W-1:0] map_arr [NUM_PER];
    logic [IDX_W-1:0] mapped;

    for (genvar b = 0; b < NUM_PER; b++) begin : g_map
        assign map_arr[b] = map_flat[b*IDX_W +: IDX_W];
    end

    always_comb begin
        mapped = band;
        if (ctrl.remap && band <= MAX_IDX)
            mapped = map_arr[band];
        idx = clamp_idx(ctrl.manual ? ctrl.force_idx : mapped);
    end

endmodule

// File: rtl/rfgen_interval_timer.sv
module rfgen_interval_timer
    import rfgen_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sr_en,
    input  logic [IDX_W-1:0] next_idx,
    output logic             pulse,
    output logic [IDX_W-1:0] act_idx,
    output logic             owed,
    output logic             running
);

    localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam int EL_W  = TICK_W + PRE_W + 2;

    run_state_t        state;
    logic [PRE_W-1:0]  pre;
    logic [TICK_W-1:0] ticks;
    logic [TICK_W-1:0] cur_ticks;
    logic [EL_W-1:0]   elapsed;
    logic [EL_W-1:0]   span;
    logic              tick_hit;
    logic              wrap;

    assign cur_ticks = period_ticks(act_idx);
    assign tick_hit  = (pre == PRE_W'(TICK_DIV - 1));
    assign wrap      = tick_hit && ((ticks + TICK_W'(1)) == cur_ticks);
    assign elapsed   = EL_W'(ticks) * EL_W'(TICK_DIV) + EL_W'(pre);
    assign span      = EL_W'(cur_ticks) * EL_W'(TICK_DIV);
    assign running   = (state == ST_RUN);
    assign owed      = running && ({elapsed, 1'b0} > {1'b0, span});

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pre     <= '0;
            ticks   <= '0;
            act_idx <= '0;
            pulse   <= 1'b0;
        end else begin
            pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (sr_en) begin
                        state   <= ST_RUN;
                        pre     <= '0;
                        ticks   <= '0;
                        act_idx <= next_idx;
                    end
                end
                default: begin
                    if (!sr_en) begin
                        state <= ST_IDLE;
                        pulse <= owed;
                        pre   <= '0;
                        ticks <= '0;
                    end else if (tick_hit) begin
                        pre <= '0;
                        if (wrap) begin
                            ticks   <= '0;
                            pulse   <= 1'b1;
                            act_idx <= next_idx;
                        end else begin
                            ticks <= ticks + TICK_W'(1);
                        end
                    end else begin
                        pre <= pre + PRE_W'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/refresh_rate_gen.sv
module refresh_rate_gen
    import rfgen_pkg::*;
#(
    parameter int TEMP_W   = 8,
    parameter int TICK_DIV = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sr_en,
    input  logic [TEMP_W-1:0]         temp_code,
    input  logic [NUM_THR*TEMP_W-1:0] thr_flat,
    input  logic                      tm_remap_en,
    input  logic [NUM_PER*IDX_W-1:0]  tm_band_map,
    input  logic                      tm_manual_en,
    input  logic [IDX_W-1:0]          tm_manual_idx,
    output logic                      refresh_o,
    output logic [IDX_W-1:0]          period_idx_o,
    output logic                      owed_o
);

    logic [IDX_W-1:0] band;
    logic [IDX_W-1:0] next_idx;
    logic             running;
    sel_ctrl_t        ctrl;

    assign ctrl = '{manual: tm_manual_en, remap: tm_remap_en, force_idx: tm_manual_idx};

    rfgen_band_cmp #(.TEMP_W(TEMP_W)) u_band (
        .temp     (temp_code),
        .thr_flat (thr_flat),
        .band     (band)
    );

    rfgen_period_sel u_sel (
        .band     (band),
        .map_flat (tm_band_map),
        .ctrl     (ctrl),
        .idx      (next_idx)
    );

    rfgen_interval_timer #(.TICK_DIV(TICK_DIV)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .sr_en    (sr_en),
        .next_idx (next_idx),
        .pulse    (refresh_o),
        .act_idx  (period_idx_o),
        .owed     (owed_o),
        .running  (running)
    );

endmodule

// File: rtl/refresh_rate_gen_chk.sv
module refresh_rate_gen_chk
    import rfgen_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sr_en,
    input logic             refresh_o,
    input logic [IDX_W-1:0] period_idx_o,
    input logic             owed_o,
    input logic             running
);

    assert_pulse_single_R1: assert property (@(posedge clk) disable iff (rst)
        refresh_o |=> !refresh_o);

    // Clamping of remapped and forced indices (R5, R6)
    assert_idx_range_R6: assert property (@(posedge clk) disable iff (rst)
        period_idx_o <= MAX_IDX);

    assert_idx_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(period_idx_o) |-> (refresh_o || !$past(running)));

    assert_idle_silent_R8: assert property (@(posedge clk) disable iff (rst)
        (!running && !$past(running)) |-> !refresh_o);

    assert_owed_running_R9: assert property (@(posedge clk) disable iff (rst)
        owed_o |-> running);

    assert_exit_catchup_R10: assert property (@(posedge clk) disable iff (rst)
        (running && !sr_en && owed_o) |=> refresh_o);

    assert_exit_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (running && !sr_en && !owed_o) |=> !refresh_o);

endmodule

bind refresh_rate_gen refresh_rate_gen_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sr_en        (sr_en),
    .refresh_o    (refresh_o),
    .period_idx_o (period_idx_o),
    .owed_o       (owed_o),
    .running      (running)
);

// File: tb/tb_refresh_rate_gen.sv
module tb_refresh_rate_gen;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sr_en = 1'b0;
    logic [7:0]  temp_code = 8'd10;
    logic [39:0] thr_flat;
    logic        tm_remap_en = 1'b0;
    logic [17:0] tm_band_map;
    logic        tm_manual_en = 1'b0;
    logic [2:0]  tm_manual_idx = 3'd0;
    logic        refresh_o;
    logic [2:0]  period_idx_o;
    logic        owed_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // 85, 65, 45, 25, 0 degC expressed as 1.25 degC codes from -40
    localparam logic [39:0] THR_DEF = {8'd32, 8'd52, 8'd68, 8'd84, 8'd100};
    localparam logic [17:0] MAP_ID  = {3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};

    always #10 clk = ~clk;

    refresh_rate_gen #(.TEMP_W(8), .TICK_DIV(DIV)) dut (
        .clk           (clk),
        .rst           (rst),
        .sr_en         (sr_en),
        .temp_code     (temp_code),
        .thr_flat      (thr_flat),
        .tm_remap_en   (tm_remap_en),
        .tm_band_map   (tm_band_map),
        .tm_manual_en  (tm_manual_en),
        .tm_manual_idx (tm_manual_idx),
        .refresh_o     (refresh_o),
        .period_idx_o  (period_idx_o),
        .owed_o        (owed_o)
    );

    function automatic int ticks_of(input int idx);
        int t [6] = '{1, 2, 4, 8, 12, 16};
        return t[idx];
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Counts negedges until refresh_o is seen high; returns -1 on timeout.
    task automatic wait_pulse(output int n);
        n = -1;
        for (int i = 1; i <= 200; i++) begin
            @(negedge clk);
            if (refresh_o) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic stop_run();
        sr_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "refresh after reset", int'(refresh_o), 0);
        chk("R1", "index after reset", int'(period_idx_o), 0);
        chk("R1", "owed after reset", int'(owed_o), 0);
    endtask

    // Start a run at a temperature and check index, first latency and interval.
    task automatic t_band(input logic [7:0] t, input int exp_idx, input string req);
        int n;
        temp_code = t;
        sr_en = 1'b1;
        @(negedge clk);
        chk(req, "index at start", int'(period_idx_o), exp_idx);
        wait_pulse(n);
        chk("R8", "first pulse latency", n + 1, ticks_of(exp_idx) * DIV + 1);
        @(negedge clk);
        chk("R1", "pulse width", int'(refresh_o), 0);
        wait_pulse(n);
        chk("R2", "pulse interval", n + 1, ticks_of(exp_idx) * DIV);
        stop_run();
    endtask

    task automatic t_default_bands();
        t_band(8'd110, 0, "R3");
        t_band(8'd90,  1, "R4");
        t_band(8'd70,  2, "R4");
        t_band(8'd60,  3, "R4");
        t_band(8'd40,  4, "R4");
        t_band(8'd10,  5, "R4");
    endtask

    task automatic t_threshold_edges();
        temp_code = 8'd100;
        sr_en = 1'b1;
        @(negedge clk);
        chk("R3", "code equal to hot threshold", int'(period_idx_o), 0);
        stop_run();
        temp_code = 8'd99;
        sr_en = 1'b1;
        @(negedge clk);
        chk("R3", "code one below threshold", int'(period_idx_o), 1);
        stop_run();
        temp_code = 8'd31;
        sr_en = 1'b1;
        @(negedge clk);
        chk("R3", "code below coldest threshold", int'(period_idx_o), 5);
        stop_run();
    endtask

    task automatic t_remap();
        tm_remap_en = 1'b1;
        tm_band_map = {3'd5, 3'd4, 3'd3, 3'd5, 3'd1, 3'd7};
        t_band(8'd70, 5, "R5");
        t_band(8'd110, 5, "R5");
        t_band(8'd90, 1, "R5");
        tm_band_map = MAP_ID;
        tm_remap_en = 1'b0;
    endtask

    task automatic t_manual();
        tm_remap_en = 1'b1;
        tm_band_map = {3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0};
        tm_manual_en = 1'b1;
        tm_manual_idx = 3'd1;
        t_band(8'd10, 1, "R6");
        tm_manual_idx = 3'd6;
        t_band(8'd110, 5, "R6");
        tm_manual_en = 1'b0;
        tm_remap_en = 1'b0;
        tm_band_map = MAP_ID;
    endtask

    task automatic t_boundary();
        int n;
        temp_code = 8'd10;
        sr_en = 1'b1;
        wait_pulse(n);
        repeat (10) @(negedge clk);
        temp_code = 8'd110;
        @(negedge clk);
        chk("R7", "index held mid-interval", int'(period_idx_o), 5);
        wait_pulse(n);
        chk("R7", "old interval completes", n + 11, 16 * DIV);
        chk("R7", "new index at pulse", int'(period_idx_o), 0);
        wait_pulse(n);
        chk("R7", "new interval length", n, DIV);
        stop_run();
    endtask

    task automatic t_exit(input int m, input int exp_owed);
        int n;
        temp_code = 8'd10;
        sr_en = 1'b1;
        wait_pulse(n);
        repeat (m) @(negedge clk);
        chk("R9", "owed flag before exit", int'(owed_o), exp_owed);
        sr_en = 1'b0;
        @(negedge clk);
        chk("R10", "catch-up pulse on exit", int'(refresh_o), exp_owed);
        chk("R9", "owed cleared when idle", int'(owed_o), 0);
        n = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (refresh_o) n++;
        end
        chk("R8", "no pulses while idle", n, 0);
    endtask

    initial begin
        thr_flat = THR_DEF;
        tm_band_map = MAP_ID;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_default_bands();
        t_threshold_edges();
        t_remap();
        t_manual();
        t_boundary();
        t_exit(32, 0);
        t_exit(33, 1);
        t_exit(10, 0);
        t_exit(60, 1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule